// File: doc/BRIEF.md
# Edge-Capturing Interrupt Flag and Mask Controller

This block sits on a board-level logic device. It collects interrupt requests from external sources and presents one combined interrupt line to a host processor. Each connected input is sampled on the system clock. A rising edge sets a sticky pending flag, and the flag stays set until software clears it. A mask register then decides which pending flags may reach the combined output.

Software sees two 16-bit registers on a simple read/write bus with halfword addressing. The address port carries the halfword index, which is the byte offset divided by two. In the default configuration only sources 8, 9 and 10 are connected, and all three start out blocked. Software finds the sources it must service by reading the flag register and the mask register and scanning the bits itself. It then acknowledges each source by writing a zero to that source's flag bit and a one to every other bit.

Top module: `edge_irq_ctrl`

## Requirements
- R1: The flag register is at halfword index 1 (byte offset 0x02) and the mask register is at halfword index 5 (byte offset 0x0A). `bus_addr` carries the halfword index.
- R2: Synchronous active-low reset sets the mask register to 0x0700, the flag register to 0x0000 and `irq_out` to 0.
- R3: A write to the flag register clears each flag bit whose write-data bit is 0 and leaves each flag bit whose write-data bit is 1 unchanged.
- R4: A connected input sets its flag bit when two consecutive samples of that input are 0 and then 1. The flag stays set until it is cleared. An input that stays high does not set the flag again after a clear.
- R5: Only inputs 8, 9 and 10 are connected. Flag bits 0-7 and 11-15 always read as 0, whatever their inputs do.
- R6: `irq_out` is a register that follows, one clock later, the OR of all bits of (flags AND NOT mask AND 0x0700).
- R7: A mask bit of 1 blocks its source and a mask bit of 0 enables it. A masked source still latches its flag, and `irq_out` rises once that mask bit is cleared.
- R8: All 16 mask bits can be written and read back. Mask bits 0-7 and 11-15 have no effect on `irq_out`.
- R9: A write to any index other than 1 or 5 changes no register. A read from such an index returns 0.
- R10: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds that value until the next read.
- R11: If a new rising edge and a write that clears the same flag bit occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 16 | External interrupt request lines, one per source |
| bus_addr | input | 3 | Halfword index of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
The assertions check on every cycle that the output tracks the unmasked pending flags with one cycle of latency. They also check that flags fall only where a flag write carries a zero, that the mask changes only on a mask write, and that reads from unused or connected indices return zeros in the right bits. Only the bench's scenarios can show the behaviour that depends on stimulus history. That covers edge detection rather than level detection, a masked source latching and then appearing once it is unmasked, the reset values seen over the bus, writes to unused indices changing nothing, and the collision in which a set and a clear land in the same cycle.

// File: rtl/edge_irq_pkg.sv
// Package: edge_irq_pkg
// Shared constants and types for the edge interrupt controller.
// Assumes a 16-bit register file addressed by halfword index.
package edge_irq_pkg;

    // Register selection produced by the address decoder
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    localparam int unsigned EIC_DATA_W    = 16;
    localparam int unsigned EIC_ADDR_W    = 3;
    localparam int unsigned EIC_FLAG_IDX  = 1;
    localparam int unsigned EIC_MASK_IDX  = 5;
    localparam logic [15:0] EIC_WIRED     = 16'h0700;
    localparam logic [15:0] EIC_MASK_INIT = 16'h0700;

endpackage

// File: rtl/eic_edge_detect.sv
// Module: eic_edge_detect
// Samples each request line twice in a row and reports a one-cycle
// rise pulse on lines listed in WIRED when the older sample is 0 and
// the newer sample is 1.
// Assumes request lines are already synchronous to clk.
module eic_edge_detect #(
    parameter int unsigned N     = 16,
    parameter logic [N-1:0] WIRED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    output logic [N-1:0] rise
);

    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Two-deep sample history for one request line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q[i]  <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                cur_q[i]  <= req_in[i];
                prev_q[i] <= cur_q[i];
            end
        end

        // Rise pulse, forced low on unconnected lines
        assign rise[i] = cur_q[i] & ~prev_q[i] & WIRED[i];
    end

endmodule

// File: rtl/eic_flag_reg.sv
// Module: eic_flag_reg
// Sticky pending flags. A rise pulse sets a bit. A write clears the
// bits written as zero. When both land on a bit in the same cycle,
// the set wins.
// Assumes rise is zero on unconnected bits, so those bits never set.
module eic_flag_reg #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flags
);

    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        // A bit is cleared only by a flag write carrying zero
        assign clr = wr_en & ~wdata[i];

        // Per-bit sticky latch with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (rise[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/eic_mask_reg.sv
// Module: eic_mask_reg
// Plain read/write mask storage. A 1 blocks the matching source.
// Assumes the top gates unconnected bits out of the output logic.
module eic_mask_reg #(
    parameter int unsigned N    = 16,
    parameter logic [N-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);

    logic [N-1:0] mask_q;

    // Load all bits on a mask write, reset to INIT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= INIT;
        end else if (wr_en) begin
            mask_q <= wdata;
        end
    end

    assign mask = mask_q;

endmodule

// File: rtl/eic_bus_decode.sv
// Module: eic_bus_decode
// Decodes the halfword index into write enables and registers the
// read data. Unused indices ignore writes and read as zero.
// Read data is updated only when a read strobe is sampled.
module eic_bus_decode
    import edge_irq_pkg::*;
#(
    parameter int unsigned N        = 16,
    parameter int unsigned AW       = 3,
    parameter int unsigned FLAG_IDX = 1,
    parameter int unsigned MASK_IDX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [N-1:0]  flags,
    input  logic [N-1:0]  mask,
    output logic          flag_wr_en,
    output logic          mask_wr_en,
    output logic [N-1:0]  rdata
);

    localparam logic [AW-1:0] FLAG_A = AW'(FLAG_IDX);
    localparam logic [AW-1:0] MASK_A = AW'(MASK_IDX);

    reg_sel_e     sel;
    logic [N-1:0] rd_mux;
    logic [N-1:0] rdata_q;

    // Map the index to a register select
    always_comb begin
        if (addr == FLAG_A) begin
            sel = SEL_FLAG;
        end else if (addr == MASK_A) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign flag_wr_en = wr && (sel == SEL_FLAG);
    assign mask_wr_en = wr && (sel == SEL_MASK);

    // Choose the read source, zero when no register is selected
    always_comb begin
        unique case (sel)
            SEL_FLAG: rd_mux = flags;
            SEL_MASK: rd_mux = mask;
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: edge_irq_ctrl
// Top of the edge interrupt controller. It captures rising edges on
// the connected sources into sticky flags, gates them with a mask and
// drives one registered interrupt line to the host.
// Assumes irq_in is synchronous to clk and that the bus issues
// single-cycle strobes.
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int unsigned  DATA_W    = EIC_DATA_W,
    parameter int unsigned  ADDR_W    = EIC_ADDR_W,
    parameter int unsigned  FLAG_IDX  = EIC_FLAG_IDX,
    parameter int unsigned  MASK_IDX  = EIC_MASK_IDX,
    parameter logic [DATA_W-1:0] WIRED     = EIC_WIRED,
    parameter logic [DATA_W-1:0] MASK_INIT = EIC_MASK_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [DATA_W-1:0] rise;
    logic [DATA_W-1:0] flags;
    logic [DATA_W-1:0] mask;
    logic              flag_wr_en;
    logic              mask_wr_en;
    logic              irq_d;
    logic              irq_q;

    eic_edge_detect #(
        .N     (DATA_W),
        .WIRED (WIRED)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (irq_in),
        .rise   (rise)
    );

    eic_flag_reg #(
        .N (DATA_W)
    ) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .wr_en (flag_wr_en),
        .wdata (bus_wdata),
        .flags (flags)
    );

    eic_mask_reg #(
        .N    (DATA_W),
        .INIT (MASK_INIT)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_wr_en),
        .wdata (bus_wdata),
        .mask  (mask)
    );

    eic_bus_decode #(
        .N        (DATA_W),
        .AW       (ADDR_W),
        .FLAG_IDX (FLAG_IDX),
        .MASK_IDX (MASK_IDX)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .flags      (flags),
        .mask       (mask),
        .flag_wr_en (flag_wr_en),
        .mask_wr_en (mask_wr_en),
        .rdata      (bus_rdata)
    );

    // Any connected, unmasked pending source requests service
    assign irq_d = |(flags & ~mask & WIRED);

    // Register the combined request, low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/edge_irq_ctrl_checker.sv
// Module: edge_irq_ctrl_checker
// Clocked properties on the edge interrupt controller, bound to the top.
module edge_irq_ctrl_checker #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned FLAG_IDX = 1,
    parameter int unsigned MASK_IDX = 5,
    parameter logic [DATA_W-1:0] WIRED = 16'h0700
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic [DATA_W-1:0] flags,
    input logic [DATA_W-1:0] mask
);

    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_IDX);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_IDX);

    logic pend;
    assign pend = |(flags & ~mask & WIRED);

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq_out); // R6
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq_out); // R6
    AST_FLAG_CLEAR_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FA) |=> ((($past(flags) & ~flags) & $past(bus_wdata)) == '0)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == FA) |=> ((flags & $past(flags)) == $past(flags))); // R4
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MA) |=> $stable(mask)); // R9
    AST_BAD_ADDR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != FA && bus_addr != MA) |=> (bus_rdata == '0)); // R9
    AST_UNWIRED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == FA) |=> ((bus_rdata & ~WIRED) == '0)); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind edge_irq_ctrl edge_irq_ctrl_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .FLAG_IDX (FLAG_IDX),
    .MASK_IDX (MASK_IDX),
    .WIRED    (WIRED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .flags     (flags),
    .mask      (mask)
);

// File: tb/edge_irq_ctrl_bench.sv
// Directed bench for edge_irq_ctrl: one task per scenario.
module edge_irq_ctrl_bench;

    localparam logic [2:0] A_FLAG = 3'd1;
    localparam logic [2:0] A_MASK = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    edge_irq_ctrl u_edge_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R2 irq_out in reset", {15'd0, irq_out}, 16'h0000);
        rd(A_MASK, v); check("R2 mask reset", v, 16'h0700);
        rd(A_FLAG, v); check("R2 flag reset", v, 16'h0000);
        check("R2 irq_out after reset", {15'd0, irq_out}, 16'h0000);
    endtask

    task automatic t_mask_latch();
        logic [15:0] v;
        irq_in[9] = 1'b1;
        cycles(4);
        check("R7 masked source blocked", {15'd0, irq_out}, 16'h0000);
        rd(A_FLAG, v); check("R7 masked source latched", v, 16'h0200);
        wr(A_MASK, 16'h0000);
        cycles(2);
        check("R7 irq after unmask", {15'd0, irq_out}, 16'h0001);
        wr(A_FLAG, 16'hFFFF);
        rd(A_FLAG, v); check("R3 write of ones keeps flag", v, 16'h0200);
        wr(A_FLAG, 16'hFDFF);
        rd(A_FLAG, v); check("R3 write of zero clears flag", v, 16'h0000);
        cycles(2);
        check("R6 irq drops after clear", {15'd0, irq_out}, 16'h0000);
        cycles(3);
        rd(A_FLAG, v); check("R4 steady high does not re-set", v, 16'h0000);
        irq_in[9] = 1'b0;
        cycles(3);
    endtask

    task automatic t_multi();
        logic [15:0] v;
        irq_in[8] = 1'b1; irq_in[10] = 1'b1;
        cycles(4);
        rd(A_FLAG, v); check("R4 two edges captured", v, 16'h0500);
        check("R6 irq with two pending", {15'd0, irq_out}, 16'h0001);
        wr(A_MASK, 16'h0100);
        cycles(2);
        check("R7 one source masked, one still open", {15'd0, irq_out}, 16'h0001);
        wr(A_FLAG, 16'hFBFF);
        cycles(2);
        check("R6 only masked flag left", {15'd0, irq_out}, 16'h0000);
        rd(A_FLAG, v); check("R3 clear of bit 10 only", v, 16'h0100);
        wr(A_MASK, 16'h0000);
        wr(A_FLAG, 16'hFEFF);
        irq_in[8] = 1'b0; irq_in[10] = 1'b0;
        cycles(3);
    endtask

    task automatic t_unwired();
        logic [15:0] v;
        irq_in[3] = 1'b1; irq_in[12] = 1'b1; irq_in[0] = 1'b1;
        cycles(4);
        rd(A_FLAG, v); check("R5 unconnected flags read zero", v, 16'h0000);
        check("R5 unconnected edges no irq", {15'd0, irq_out}, 16'h0000);
        irq_in = '0;
        wr(A_MASK, 16'hF8FF);
        rd(A_MASK, v); check("R8 mask readback", v, 16'hF8FF);
        irq_in[8] = 1'b1;
        cycles(4);
        check("R8 unconnected mask bits no effect", {15'd0, irq_out}, 16'h0001);
    endtask

    task automatic t_bad_addr();
        logic [15:0] v;
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'hFFFF);
        rd(A_FLAG, v); check("R9 stray writes keep flags", v, 16'h0100);
        rd(A_MASK, v); check("R9 stray writes keep mask", v, 16'hF8FF);
        rd(3'd7, v); check("R9 unused index reads zero", v, 16'h0000);
        rd(A_MASK, v);
        cycles(3);
        check("R10 read data holds", bus_rdata, 16'hF8FF);
        check("R1 flag at index 1 is live", {15'd0, irq_out}, 16'h0001);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        wr(A_FLAG, 16'hFEFF);
        irq_in[8] = 1'b0;
        cycles(3);
        rd(A_FLAG, v); check("R3 flag cleared before collision", v, 16'h0000);
        @(negedge clk);
        irq_in[8] = 1'b1;
        wr(A_FLAG, 16'hFEFF);
        rd(A_FLAG, v); check("R11 set wins over clear", v, 16'h0100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cycles(3);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_mask_latch();
        t_multi();
        t_unwired();
        t_bad_addr();
        t_set_wins();
        cycles(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic t_reset_pre();
        check("R2 irq_out low during reset", {15'd0, irq_out}, 16'h0000);
    endtask

endmodule